// File: doc/BRIEF.md
# Bus Command Queue Engine

This block sits behind a register port and turns software-written command words into single accesses on a downstream bus. Each accepted word carries a target register address, a command tag, a target device number and an eight-bit payload. A word written to the write-command offset becomes one downstream write, with the payload as the data byte. A word written to the read-command offset becomes a run of single-byte downstream reads, with the payload as the byte count. The bytes that come back are collected in a read-data queue, and software drains that queue one byte per register read.

Commands wait in a queue and are issued strictly one at a time. An access that the far end does not acknowledge is repeated until the programmed retry budget is used up. The command is then discarded, an error pulse is raised and the engine halts until software flushes it. A command tagged with the special value signals a finished pulse when it completes, so software can wait on an event instead of polling.

Top module: `cmd_queue_engine`

## Requirements
- R1: A command word is decoded as register address in bits 15:0, tag in bits 19:16, device number in bits 23:20 and payload in bits 31:24. bus_reg, bus_dev and bus_wdata carry those fields unchanged.
- R2: A register write to offset 0x300 queues one downstream write (bus_is_rd=0) whose data byte is bits 31:24 of the written word.
- R3: A register write to offset 0x304 queues a read of N bytes, where N is bits 31:24. It issues N downstream reads (bus_is_rd=1) at addresses base, base+1, and so on, wrapping at 16 bits. The returned bytes are pushed into the read-data queue in order. Each register read of offset 0x318 pops one byte into bits 7:0, and returns 0 when the queue is empty.
- R4: A read count above 15 is treated as 15. A read count of 0 completes without any downstream access.
- R5: Queued commands are issued in arrival order with only one access outstanding. bus_req stays high with stable fields until bus_done, and is low in the cycle after bus_done.
- R6: An access answered with bus_ack=0 is reissued until it has been tried 1 + L times, where L is bits 3:0 of offset 0x314. L reads back at 0x314 and resets to 7.
- R7: When the retry budget of an access runs out, the command is dropped and evt_error pulses for one cycle. Status bit 16 is then set and no further command is taken from the queue until a flush, although new words are still queued.
- R8: A register write to offset 0x308 with bit 0 set empties the command queue and clears the halt. The same write with bit 0 clear has no effect.
- R9: evt_finished pulses for one cycle when a command with tag 0xF completes. Commands with any other tag raise no pulse.
- R10: A register read of offset 0x30C returns the command queue level in bits 7:0, the read-data queue level in bits 15:8, the halt flag in bit 16 and the busy flag in bit 17. All of these are 0 after reset.
- R11: While the read-data queue is full, the next downstream read is held back. It is issued once software has popped a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops read data at 0x318) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while reg_rd is high |
| bus_req | output | 1 | Downstream access request, held until bus_done |
| bus_is_rd | output | 1 | 1 for a read access, 0 for a write access |
| bus_dev | output | 4 | Target device number |
| bus_reg | output | 16 | Target register address |
| bus_wdata | output | 8 | Write data byte |
| bus_done | input | 1 | One-cycle response strobe |
| bus_ack | input | 1 | Response acknowledged when 1 |
| bus_rdata | input | 8 | Returned byte for a read access |
| evt_finished | output | 1 | One-cycle pulse on completion of a tag-0xF command |
| evt_error | output | 1 | One-cycle pulse when a command is dropped after its retries |

## Verification
The assertions check, on every cycle, the downstream handshake: the request is held with stable fields until its response, and drops for one cycle after it. They also check that the read-data queue is never pushed while full, that a halted engine takes no command, that finished pulses come only from tag-0xF commands, and that errors come only once the retry budget is spent. The bench scenarios show the rest, comparing every downstream access against a scoreboard: address sequencing across a byte boundary, count clipping and the zero count, retry counts under nack patterns, and what a flush discards. They also show the stall on a full read queue and its release, and the byte values and order seen through the register port.

// File: rtl/cqe_pkg.sv
package cqe_pkg;
  localparam int REG_AW = 12;
  localparam logic [REG_AW-1:0] OFS_WR_CMD = 12'h300;
  localparam logic [REG_AW-1:0] OFS_RD_CMD = 12'h304;
  localparam logic [REG_AW-1:0] OFS_FLUSH  = 12'h308;
  localparam logic [REG_AW-1:0] OFS_STATUS = 12'h30C;
  localparam logic [REG_AW-1:0] OFS_RETRY  = 12'h314;
  localparam logic [REG_AW-1:0] OFS_RDDATA = 12'h318;
  localparam logic [3:0] SPECIAL_TAG = 4'hF;
  localparam int MAX_RD_BYTES = 15;

  typedef struct packed {
    logic [7:0]  payload;
    logic [3:0]  dev;
    logic [3:0]  tag;
    logic [15:0] regaddr;
  } cmd_word_t;

  typedef struct packed {
    logic      is_rd;
    cmd_word_t w;
  } cmd_entry_t;

  function automatic logic [3:0] clip_len(input logic [7:0] n);
    return (n > 8'(MAX_RD_BYTES)) ? 4'(MAX_RD_BYTES) : n[3:0];
  endfunction

  function automatic logic [15:0] byte_addr(input logic [15:0] base, input logic [3:0] idx);
    return base + 16'(idx);
  endfunction

  function automatic logic budget_spent(input logic [3:0] tries, input logic [3:0] limit);
    return tries >= limit;
  endfunction
endpackage

// File: rtl/cqe_fifo.sv
module cqe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/cqe_sequencer.sv
module cqe_sequencer
  import cqe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        q_empty,
  input  cmd_entry_t  q_head,
  output logic        q_pop,
  input  logic [3:0]  retry_lim,
  input  logic        flush,
  input  logic        rd_space,
  output logic        rd_push,
  output logic [7:0]  rd_byte,
  output logic        bus_req,
  output logic        bus_is_rd,
  output logic [3:0]  bus_dev,
  output logic [15:0] bus_reg,
  output logic [7:0]  bus_wdata,
  input  logic        bus_done,
  input  logic        bus_ack,
  input  logic [7:0]  bus_rdata,
  output logic        evt_finished,
  output logic        evt_error,
  output logic        halted,
  output logic        busy
);
  typedef enum logic [1:0] {S_IDLE, S_GAP, S_ISSUE} st_t;
  st_t        st;
  cmd_entry_t cur;
  logic [3:0] idx, tries, len_c;
  logic       last_byte, start, gap_go, gap_empty_done;
  logic       hit_ack, hit_nack, give_up, complete;

  assign len_c          = cur.is_rd ? clip_len(cur.w.payload) : 4'd1;
  assign last_byte      = ({1'b0, idx} + 5'd1) == {1'b0, len_c};
  assign start          = (st == S_IDLE) && !q_empty && !halted;
  assign q_pop          = start;
  assign gap_empty_done = (st == S_GAP) && (idx == len_c);
  assign gap_go         = (st == S_GAP) && (idx != len_c) && (!cur.is_rd || rd_space);
  assign hit_ack        = (st == S_ISSUE) && bus_done && bus_ack;
  assign hit_nack       = (st == S_ISSUE) && bus_done && !bus_ack;
  assign give_up        = hit_nack && budget_spent(tries, retry_lim);
  assign complete       = (hit_ack && last_byte) || gap_empty_done;

  assign bus_req   = (st == S_ISSUE);
  assign bus_is_rd = cur.is_rd;
  assign bus_dev   = cur.w.dev;
  assign bus_reg   = byte_addr(cur.w.regaddr, idx);
  assign bus_wdata = cur.w.payload;
  assign rd_push   = hit_ack && cur.is_rd;
  assign rd_byte   = bus_rdata;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cur          <= '0;
      idx          <= '0;
      tries        <= '0;
      evt_finished <= 1'b0;
      evt_error    <= 1'b0;
      halted       <= 1'b0;
    end else begin
      evt_finished <= complete && (cur.w.tag == SPECIAL_TAG);
      evt_error    <= give_up;
      if (flush)        halted <= 1'b0;
      else if (give_up) halted <= 1'b1;
      unique case (st)
        S_IDLE: if (start) begin
          cur   <= q_head;
          idx   <= '0;
          tries <= '0;
          st    <= S_GAP;
        end
        S_GAP: begin
          if (gap_empty_done) st <= S_IDLE;
          else if (gap_go)    st <= S_ISSUE;
        end
        S_ISSUE: if (bus_done) begin
          if (bus_ack) begin
            tries <= '0;
            if (last_byte) st <= S_IDLE;
            else begin
              idx <= idx + 4'd1;
              st  <= S_GAP;
            end
          end else if (give_up) begin
            st <= S_IDLE;
          end else begin
            tries <= tries + 4'd1;
            st    <= S_GAP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_reg) && $stable(bus_dev)));
  // R5
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done) |=> !bus_req);
  // R11
  rd_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_push |-> rd_space);
  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !q_pop);
  // R9
  fin_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_finished |-> (cur.w.tag == SPECIAL_TAG));
  // R6
  err_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_error |-> (tries >= retry_lim));
endmodule

// File: rtl/cmd_queue_engine.sv
module cmd_queue_engine
  import cqe_pkg::*;
#(
  parameter int CMD_DEPTH   = 8,
  parameter int RD_DEPTH    = 16,
  parameter int RETRY_RESET = 7,
  localparam int CCW        = $clog2(CMD_DEPTH + 1),
  localparam int RCW        = $clog2(RD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              bus_req,
  output logic              bus_is_rd,
  output logic [3:0]        bus_dev,
  output logic [15:0]       bus_reg,
  output logic [7:0]        bus_wdata,
  input  logic              bus_done,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata,
  output logic              evt_finished,
  output logic              evt_error
);
  logic       hit_wr, hit_rd, flush_req, hit_retry, pop_rd;
  cmd_entry_t q_in, q_head;
  logic       q_pop, q_full, q_empty;
  logic [CCW-1:0] q_count;
  logic       rd_push, rd_full, rd_empty;
  logic [7:0] rd_byte, rd_dout;
  logic [RCW-1:0] rd_count;
  logic [3:0] retry_q;
  logic       halted, busy;

  assign hit_wr    = reg_wr && (reg_addr == OFS_WR_CMD);
  assign hit_rd    = reg_wr && (reg_addr == OFS_RD_CMD);
  assign flush_req = reg_wr && (reg_addr == OFS_FLUSH) && reg_wdata[0];
  assign hit_retry = reg_wr && (reg_addr == OFS_RETRY);
  assign pop_rd    = reg_rd && (reg_addr == OFS_RDDATA);
  assign q_in      = '{is_rd: hit_rd, w: cmd_word_t'(reg_wdata)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         retry_q <= 4'(RETRY_RESET);
    else if (hit_retry) retry_q <= reg_wdata[3:0];
  end

  cqe_fifo #(.W($bits(cmd_entry_t)), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .flush(flush_req), .push(hit_wr || hit_rd),
    .din(q_in), .pop(q_pop), .dout(q_head), .count(q_count),
    .full(q_full), .empty(q_empty));

  cqe_fifo #(.W(8), .DEPTH(RD_DEPTH)) u_rdq (
    .clk(clk), .rst_n(rst_n), .flush(1'b0), .push(rd_push),
    .din(rd_byte), .pop(pop_rd), .dout(rd_dout), .count(rd_count),
    .full(rd_full), .empty(rd_empty));

  cqe_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
    .retry_lim(retry_q), .flush(flush_req), .rd_space(!rd_full),
    .rd_push(rd_push), .rd_byte(rd_byte),
    .bus_req(bus_req), .bus_is_rd(bus_is_rd), .bus_dev(bus_dev), .bus_reg(bus_reg),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .evt_finished(evt_finished), .evt_error(evt_error), .halted(halted), .busy(busy));

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        OFS_STATUS: reg_rdata = {14'd0, busy, halted, 8'(rd_count), 8'(q_count)};
        OFS_RETRY:  reg_rdata = {28'd0, retry_q};
        OFS_RDDATA: reg_rdata = {24'd0, rd_empty ? 8'd0 : rd_dout};
        default:    reg_rdata = '0;
      endcase
    end
  end

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (q_count == '0) && !halted);
  // R7
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_error && !$past(flush_req)) |-> halted);
  // R3
  rd_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_rd && rd_empty) |-> (reg_rdata == 32'd0));
endmodule

// File: tb/cmd_queue_engine_bench.sv
module cmd_queue_engine_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        bus_req, bus_is_rd;
  logic [3:0]  bus_dev;
  logic [15:0] bus_reg;
  logic [7:0]  bus_wdata;
  logic        bus_done = 0, bus_ack = 0;
  logic [7:0]  bus_rdata = 0;
  logic        evt_finished, evt_error;

  always #2 clk = ~clk;

  cmd_queue_engine u_cmd_queue_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_is_rd(bus_is_rd),
    .bus_dev(bus_dev), .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_done(bus_done),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .evt_finished(evt_finished), .evt_error(evt_error));

  typedef struct { logic is_rd; logic [3:0] dev; logic [15:0] ra; logic [7:0] wd; } exp_t;
  exp_t       exp_q[$];
  logic       ack_q[$];
  logic [7:0] rdexp_q[$];
  int errors = 0, checks = 0, fin_cnt = 0, err_cnt = 0;
  bit finished_run = 0;

  always @(posedge clk) begin
    if (evt_finished) fin_cnt++;
    if (evt_error) err_cnt++;
  end

  function automatic logic [7:0] resp_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // monitor / responder: compares every downstream access with the scoreboard
  initial begin
    int d = 0;
    forever begin
      @(negedge clk);
      if (bus_req) begin
        exp_t e;
        repeat (d % 3) @(negedge clk);
        d++;
        if (exp_q.size() == 0) begin
          chk(0, "R5 unexpected access", {bus_is_rd, bus_reg}, 0);
        end else begin
          e = exp_q.pop_front();
          chk(bus_is_rd == e.is_rd && bus_dev == e.dev && bus_reg == e.ra &&
              (e.is_rd || bus_wdata == e.wd), "R1 access fields",
              {bus_is_rd, bus_dev, bus_reg, bus_wdata}, {e.is_rd, e.dev, e.ra, e.wd});
        end
        bus_ack   = (ack_q.size() > 0) ? ack_q.pop_front() : 1'b1;
        bus_rdata = resp_byte(bus_reg);
        bus_done  = 1;
        @(negedge clk);
        bus_done  = 0;
      end
    end
  end

  task automatic reg_write(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  function automatic logic [31:0] pack(input logic [7:0] p, input logic [3:0] dv,
                                       input logic [3:0] tg, input logic [15:0] ra);
    return {p, dv, tg, ra};
  endfunction

  // driver: write command, with nacks nacks before an ack (or exhaustion)
  task automatic send_write(input logic [3:0] dv, input logic [3:0] tg, input logic [15:0] ra,
                            input logic [7:0] data, input int tries, input bit ok);
    for (int i = 0; i < tries; i++) begin
      exp_q.push_back('{is_rd: 1'b0, dev: dv, ra: ra, wd: data});
      ack_q.push_back(ok && (i == tries - 1));
    end
    reg_write(12'h300, pack(data, dv, tg, ra));
  endtask

  task automatic send_read(input logic [3:0] dv, input logic [3:0] tg, input logic [15:0] ra,
                           input logic [7:0] n);
    int m = (n > 15) ? 15 : int'(n);
    for (int i = 0; i < m; i++) begin
      logic [15:0] a = ra + 16'(i);
      exp_q.push_back('{is_rd: 1'b1, dev: dv, ra: a, wd: 8'h00});
      ack_q.push_back(1'b1);
      rdexp_q.push_back(resp_byte(a));
    end
    reg_write(12'h304, pack(n, dv, tg, ra));
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do reg_read(12'h30C, s);
    while (s[17] || (s[7:0] != 0 && !s[16]));
  endtask

  task automatic pop_bytes(input int n, input string tag);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      logic [7:0] e = rdexp_q.pop_front();
      reg_read(12'h318, v);
      chk(v == {24'd0, e}, tag, v, e);
    end
  endtask

  initial begin
    logic [31:0] v;
    int f0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    reg_read(12'h30C, v); chk(v == 0, "R10 reset status", v, 0);
    reg_read(12'h314, v); chk(v == 7, "R6 retry reset", v, 7);
    reg_read(12'h318, v); chk(v == 0, "R3 empty pop", v, 0);

    // plain write, non-special tag: no finished pulse
    f0 = fin_cnt;
    send_write(4'd3, 4'd2, 16'h1234, 8'hA5, 1, 1); wait_idle();
    chk(fin_cnt == f0, "R9 no pulse tag 2", fin_cnt, f0);
    chk(exp_q.size() == 0, "R2 write issued", exp_q.size(), 0);

    // special tag write
    send_write(4'd9, 4'hF, 16'hBEEF, 8'h5A, 1, 1); wait_idle();
    chk(fin_cnt == f0 + 1, "R9 pulse tag F", fin_cnt, f0 + 1);

    // read across byte boundary
    send_read(4'd5, 4'hF, 16'h00FE, 8'd4); wait_idle();
    reg_read(12'h30C, v); chk(v[15:8] == 4, "R10 rd level", v[15:8], 4);
    chk(fin_cnt == f0 + 2, "R9 pulse on read", fin_cnt, f0 + 2);
    pop_bytes(4, "R3 read bytes");
    reg_read(12'h318, v); chk(v == 0, "R3 drained pop", v, 0);

    // clipped and zero counts
    send_read(4'd1, 4'd0, 16'hFFF8, 8'h20); wait_idle();
    reg_read(12'h30C, v); chk(v[15:8] == 15, "R4 clip to 15", v[15:8], 15);
    pop_bytes(15, "R4 clipped bytes");
    send_read(4'd2, 4'hF, 16'h0040, 8'd0); wait_idle();
    chk(fin_cnt == f0 + 3, "R4 zero count completes", fin_cnt, f0 + 3);
    reg_read(12'h30C, v); chk(v[15:8] == 0, "R4 zero count no data", v[15:8], 0);

    // retries within budget
    e0 = err_cnt;
    send_write(4'd4, 4'd1, 16'h0777, 8'h11, 3, 1); wait_idle();
    chk(err_cnt == e0 && exp_q.size() == 0, "R6 three tries", err_cnt, e0);

    // exhaustion with budget 1
    reg_write(12'h314, 32'd1);
    reg_read(12'h314, v); chk(v == 1, "R6 retry readback", v, 1);
    send_write(4'd6, 4'd3, 16'h0100, 8'h22, 2, 0); wait_idle();
    chk(err_cnt == e0 + 1, "R7 error pulse", err_cnt, e0 + 1);
    reg_read(12'h30C, v); chk(v[16] == 1, "R7 halt flag", v[16], 1);
    reg_write(12'h300, pack(8'h33, 4'd7, 4'd0, 16'h0200));
    repeat (20) @(negedge clk);
    reg_read(12'h30C, v); chk(v[7:0] == 1 && v[17] == 0, "R7 held while halted", v, 32'h10001);

    // flush
    reg_write(12'h308, 32'd0);
    reg_read(12'h30C, v); chk(v[16] == 1 && v[7:0] == 1, "R8 bit0 clear ignored", v, 32'h10001);
    reg_write(12'h308, 32'd1);
    reg_read(12'h30C, v); chk(v == 0, "R8 flush clears", v, 0);
    reg_write(12'h314, 32'd7);
    send_write(4'd8, 4'hF, 16'h0300, 8'h44, 1, 1); wait_idle();
    chk(exp_q.size() == 0 && fin_cnt == f0 + 4, "R8 resumes after flush", fin_cnt, f0 + 4);

    // order of back-to-back commands
    send_write(4'd1, 4'd0, 16'h0010, 8'h01, 1, 1);
    send_write(4'd2, 4'd0, 16'h0020, 8'h02, 1, 1);
    send_write(4'd3, 4'd0, 16'h0030, 8'h03, 1, 1);
    wait_idle();
    chk(exp_q.size() == 0, "R5 order kept", exp_q.size(), 0);

    // stall on full read queue
    send_read(4'd2, 4'd0, 16'h1000, 8'd15);
    send_read(4'd3, 4'd0, 16'h2000, 8'd15);
    do reg_read(12'h30C, v); while (v[15:8] != 16);
    repeat (12) @(negedge clk);
    reg_read(12'h30C, v);
    chk(v[15:8] == 16 && v[17] == 1, "R11 stalled while full", v, 32'h21000);
    pop_bytes(16, "R11 first bytes");
    wait_idle();
    pop_bytes(14, "R11 resumed bytes");
    chk(exp_q.size() == 0, "R11 all accesses", exp_q.size(), 0);

    finished_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished_run) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule